// File: doc/BRIEF.md
# Two-Phase Turing Machine Stepper

This block is a single-tape, two-symbol Turing machine core. The tape is a bidirectional shift register. The head is a fixed cell in its middle, so moving the head means shifting the whole tape. A transition table sits inside the block as a parameter. It is indexed by the current state and the symbol under the head, and it supplies a write flag, the symbol to write, a two-bit move code and the next state.

Each machine step takes two clock cycles. In the first cycle (write phase) the head cell is loaded with the symbol, or left alone when the write flag is clear. The move code and the next state are captured from the table entry in this cycle. In the second cycle (move phase) the tape shifts and the captured next state is committed. One decoder turns the phase, the write flag and the move code into a two-bit shift-register mode.

A raw clear input passes through two synchroniser flops before it acts. The default table is the three-state busy beaver.

Top module: `tm_stepper`

## Requirements
- R1: The raw clear acts through two flops. The third rising edge after it goes high, and every edge while it stays high, leaves the tape all zero, the step count zero, halted low, the state at 0 and the phase at write.
- R2: In the write phase, a table entry with write flag 1 sets the head cell (bit HEAD of the tape) to the entry's symbol and leaves every other cell unchanged. A write flag of 0 leaves the whole tape unchanged.
- R3: In the move phase, move code 01 shifts the tape toward lower indices: cell i takes cell i+1 and a 0 enters the top cell. Move code 10 shifts toward higher indices: cell i takes cell i-1 and a 0 enters cell 0.
- R4: In the move phase, move codes 00 and 11 leave the tape unchanged. The write flag and symbol have no effect in this phase.
- R5: The move code and the next state come from the entry read in the write phase, before the head cell was rewritten. The state changes only at the end of the move phase.
- R6: The step count rises by one at the end of each move phase and holds at its all-ones maximum.
- R7: While run is low, the tape, the step count and the state do not change, and the phase does not advance.
- R8: The all-ones state code is the halt state. In it, halted is high and the tape and step count stay frozen.
- R9: A table entry at index {state, symbol} is packed as {write, symbol, move[1:0], next[STATE_W-1:0]}, and the machine starts in state 0. With the default table (three-state busy beaver), the machine halts after 14 steps with six 1 cells on the tape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr_raw_i | input | 1 | Raw clear, asynchronous to clk, active high |
| run_i | input | 1 | Run enable |
| halted_o | output | 1 | Machine is in the halt state |
| steps_o | output | CNT_W | Completed step count, saturating |
| tape_o | output | TAPE_W | Tape contents, head at bit HEAD |

## Verification
The bench builds two instances. The first uses the default 32-cell tape, 16-bit counter and busy-beaver table, and it is compared step by step against a reference walk of that table, including the write-phase midpoint. The second uses a 4-bit counter and a custom table. That table brings in the hold move codes 00 and 11, a cleared write flag paired with a set symbol bit, a marked cell shifting off the low end, and counter saturation after 15 steps.

// File: rtl/tm_stepper.sv
module tm_stepper #(
  parameter int TAPE_W  = 32,
  parameter int HEAD    = 16,
  parameter int STATE_W = 2,
  parameter int CNT_W   = 16,
  parameter logic [(2**(STATE_W+1))*(STATE_W+4)-1:0] PROG = {
    6'b000000, 6'b000000,
    6'b011000, 6'b111010,
    6'b010101, 6'b000110,
    6'b010111, 6'b110101 }
) (
  input  logic              clk,
  input  logic              clr_raw_i,
  input  logic              run_i,
  output logic              halted_o,
  output logic [CNT_W-1:0]  steps_o,
  output logic [TAPE_W-1:0] tape_o
);
  localparam int ENT_W = STATE_W + 4;
  localparam logic [STATE_W-1:0] HALT = {STATE_W{1'b1}};
  localparam logic [CNT_W-1:0]   CMAX = {CNT_W{1'b1}};

  logic clr_m, clr_q;
  logic phase;
  logic [STATE_W-1:0] state, nxt_q;
  logic [1:0] mv_q, mode;
  logic [STATE_W:0] idx;
  logic [ENT_W-1:0] entry;
  logic go;

  always_ff @(posedge clk) begin
    clr_m <= clr_raw_i;
    clr_q <= clr_m;
  end

  assign idx      = {state, tape_o[HEAD]};
  assign entry    = PROG[idx*ENT_W +: ENT_W];
  assign halted_o = (state == HALT);
  assign go       = run_i && !halted_o;

  always_comb begin
    mode = 2'b00;
    if (go) begin
      if (!phase) mode = entry[ENT_W-1] ? 2'b11 : 2'b00;
      else if (mv_q == 2'b01 || mv_q == 2'b10) mode = mv_q;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_q) tape_o <= '0;
    else case (mode)
      2'b11: tape_o[HEAD] <= entry[ENT_W-2];
      2'b01: tape_o <= {1'b0, tape_o[TAPE_W-1:1]};
      2'b10: tape_o <= {tape_o[TAPE_W-2:0], 1'b0};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr_q) begin
      phase   <= 1'b0;
      state   <= '0;
      nxt_q   <= '0;
      mv_q    <= 2'b00;
      steps_o <= '0;
    end else if (go) begin
      phase <= ~phase;
      if (!phase) begin
        mv_q  <= entry[STATE_W +: 2];
        nxt_q <= entry[STATE_W-1:0];
      end else begin
        state <= nxt_q;
        if (steps_o != CMAX) steps_o <= steps_o + 1'b1;
      end
    end
  end

  p_clear_r1: assert property (@(posedge clk)
    clr_q |=> (tape_o == '0 && steps_o == '0 && !halted_o));

  p_others_kept_r2: assert property (@(posedge clk) disable iff (clr_q)
    (go && !phase) |=> ((tape_o ^ $past(tape_o)) & ~(TAPE_W'(1) << HEAD)) == '0);

  p_hold_move_r4: assert property (@(posedge clk) disable iff (clr_q)
    (go && phase && (mv_q == 2'b00 || mv_q == 2'b11)) |=> $stable(tape_o));

  p_state_held_r5: assert property (@(posedge clk) disable iff (clr_q)
    (go && !phase) |=> $stable(state));

  p_step_inc_r6: assert property (@(posedge clk) disable iff (clr_q)
    (go && phase && steps_o != CMAX) |=> steps_o == $past(steps_o) + 1'b1);

  p_saturate_r6: assert property (@(posedge clk) disable iff (clr_q)
    (steps_o == CMAX) |=> steps_o == CMAX);

  p_idle_r7: assert property (@(posedge clk) disable iff (clr_q)
    !run_i |=> ($stable(tape_o) && $stable(steps_o) && $stable(phase)));

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (clr_q)
    halted_o |=> ($stable(tape_o) && $stable(steps_o) && halted_o));
endmodule

// File: tb/tm_stepper_tb.sv
module tm_stepper_tb;
  localparam int TW = 32;
  localparam int HD = 16;

  // R9 rules {wr, sym, move, next} indexed by {state, symbol}
  localparam logic [5:0] RULES [8] = '{
    6'b110101, 6'b010111, 6'b000110, 6'b010101,
    6'b111010, 6'b011000, 6'b000000, 6'b000000 };

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic run1 = 1'b0, run2 = 1'b0;
  logic halted1, halted2;
  logic [15:0] steps1;
  logic [3:0]  steps2;
  logic [TW-1:0] tape1, tape2;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tm_stepper u_dut (.clk(clk), .clr_raw_i(clr), .run_i(run1),
    .halted_o(halted1), .steps_o(steps1), .tape_o(tape1));

  tm_stepper #(.CNT_W(4), .PROG({
      6'b000000, 6'b000000, 6'b010110, 6'b010110,
      6'b001110, 6'b000000, 6'b000000, 6'b110001 }))
    u_dut2 (.clk(clk), .clr_raw_i(clr), .run_i(run2),
    .halted_o(halted2), .steps_o(steps2), .tape_o(tape2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] m_tape, m_mid;
    logic [1:0] m_state;
    logic [5:0] e;
    int m_steps, ones;

    cyc(4);
    chk("R1 tape", tape1, 0);
    chk("R1 steps", steps1, 0);
    chk("R1 halted", halted1, 0);
    clr = 1'b0;
    cyc(4);

    m_tape = '0; m_state = 2'd0; m_steps = 0;
    run1 = 1'b1;
    for (int k = 0; k < 20 && m_state != 2'd3; k++) begin
      e = RULES[{m_state, m_tape[HD]}];
      m_mid = m_tape;
      if (e[5]) m_mid[HD] = e[4];
      cyc(1);
      chk("R2 write phase tape", tape1, m_mid);
      chk("R5 steps mid-step", steps1, m_steps);
      case (e[3:2])
        2'b01: m_tape = {1'b0, m_mid[TW-1:1]};
        2'b10: m_tape = {m_mid[TW-2:0], 1'b0};
        default: m_tape = m_mid;
      endcase
      m_state = e[1:0];
      m_steps++;
      cyc(1);
      chk("R3 move phase tape", tape1, m_tape);
      chk("R6 step count", steps1, m_steps);
      chk("R8 halted flag", halted1, m_state == 2'd3);
      if (k == 5) begin
        run1 = 1'b0;
        cyc(5);
        chk("R7 paused tape", tape1, m_tape);
        chk("R7 paused steps", steps1, m_steps);
        run1 = 1'b1;
      end
    end

    cyc(6);
    chk("R8 frozen tape", tape1, m_tape);
    chk("R8 frozen halted", halted1, 1);
    chk("R9 total steps", steps1, 14);
    ones = $countones(tape1);
    chk("R9 ones on tape", ones, 6);

    run1 = 1'b0;
    clr = 1'b1;
    cyc(3);
    chk("R1 re-clear tape", tape1, 0);
    chk("R1 re-clear steps", steps1, 0);
    chk("R1 re-clear halted", halted1, 0);
    clr = 1'b0;
    cyc(4);

    run2 = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      cyc(2);
      if (k <= 2) chk("R4 hold moves keep tape", tape2, TW'(1) << HD);
      else if (k <= 18) chk("R4 write ignored, shift", tape2, TW'(1) << (18 - k));
      else chk("R3 zero fill", tape2, 0);
      chk("R6 saturating count", steps2, (k > 15) ? 15 : k);
    end
    chk("R8 never halts", halted2, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule